// File: doc/BRIEF.md
# Externally Triggered Up-Counter

This block is an up-counter whose run/stop state is controlled by hardware from one of two external pins, not by software. Each pin can be routed to either of two input channels. Each channel synchronizes its signal to the clock, can optionally filter it, and then detects edges or levels of a chosen sense. A mode field picks how the selected channel drives the counter. In trigger mode, an active edge starts the counter and the counter keeps running. In gated mode, the counter runs only while the channel sits at its active level.

A sticky interrupt flag marks the hardware events that matter. Software clears it by pulsing a clear input. When enabled, the counter advances once per clock and returns to zero after it reaches a programmable reload value. All configuration arrives as plain register-style input fields.

Top module: `stt_timer`

## Requirements
- R1: After reset, `count` is 0, `cnt_en` is 0 and `trig_flag` is 0.
- R2: With `mode_sel`=110 (trigger mode), an active edge on the selected channel sets `cnt_en`, and the counter then increments on every clock. With no filter, an input change made between clock edges shows `cnt_en`=1 after the fourth following edge and `count`=1 after the fifth. The path is two synchronizer flops, one filter flop, one enable flop and the counter.
- R3: In trigger mode, an active edge that arrives while `cnt_en` is already 1 neither clears nor restarts `count`. It only sets `trig_flag` again.
- R4: `trig_flag` is set by each trigger-mode active edge and stays set until `flag_clr` is high at a clock edge. If a set and a clear occur together, the set wins.
- R5: `trig_src`=00101 selects channel 1 and `trig_src`=00110 selects channel 2. Any other value selects nothing, so no edge or level reaches the controller.
- R6: The routing field for channel i is `ch_route[2i+1:2i]`. The value 01 feeds the channel from `ext_in[i]`, 10 feeds it from the other pin, and 00 or 11 hold the channel low.
- R7: The edge sense of channel i comes from {`pol_p[i]`,`pol_np[i]`}. The value 00 (or 01) selects rising edges, 10 selects falling edges and 11 selects both edges.
- R8: When `filt_len`=N with N>1, a new channel level is accepted only after N consecutive samples at that level. This adds N-1 clocks of delay and rejects pulses shorter than N clocks. N=0 and N=1 both mean no filtering.
- R9: With `mode_sel`=101 (gated mode), `cnt_en` follows the channel level. The level is active high when `pol_p[i]`=0 and active low when `pol_p[i]`=1, and `pol_np` is ignored. `count` holds its value while `cnt_en` is 0.
- R10: In gated mode, `trig_flag` is set both when `cnt_en` rises and when it falls.
- R11: When enabled and `count` equals `reload`, the next clock sets `count` to 0.
- R12: In any other `mode_sel` value, `cnt_en` is cleared on the next clock and `count` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_in | input | 2 | External pins, asynchronous to clk |
| mode_sel | input | 3 | Slave mode: 101 gated, 110 trigger, other off |
| trig_src | input | 5 | Trigger source: 00101 channel 1, 00110 channel 2 |
| ch_route | input | 4 | Per-channel pin routing, 2 bits per channel |
| pol_p | input | 2 | Per-channel inverted-sense bit |
| pol_np | input | 2 | Per-channel both-edges companion bit |
| filt_len | input | 4 | Filter sample count, 0 means none |
| reload | input | 16 | Value at which the counter wraps to zero |
| flag_clr | input | 1 | Clears trig_flag at the clock edge |
| count | output | 16 | Counter value |
| cnt_en | output | 1 | Counter enable state |
| trig_flag | output | 1 | Sticky trigger interrupt flag |

## Verification
The assertions assume that configuration fields change only while the selected channel is quiet. They also assume that `reload` is never set below the current count. The stimulus therefore changes `mode_sel`, `trig_src`, routing and polarity only while the pins have been steady for several clocks, and it applies `reload` during reset. Pins are driven on the falling clock edge, so the synchronizer always captures a clean value and the edge-to-count delay is deterministic.

// File: rtl/stt_pkg.sv
`timescale 1ns/1ps
package stt_pkg;
   localparam int         NCH      = 2;
   localparam logic [2:0] SM_GATED = 3'b101;
   localparam logic [2:0] SM_TRIG  = 3'b110;
   localparam logic [4:0] SRC_CH1  = 5'b00101;
   localparam logic [4:0] SRC_CH2  = 5'b00110;
   localparam logic [1:0] RT_OWN   = 2'b01;
   localparam logic [1:0] RT_SWAP  = 2'b10;
endpackage

// File: rtl/stt_in_cond.sv
`timescale 1ns/1ps
module stt_in_cond #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_W      = 4,
   parameter bit USE_FILTER  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              raw_i,
   input  logic [FILT_W-1:0] flen_i,
   output logic              clean_o
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("stt_in_cond: SYNC_STAGES must be at least 2");
   end
   if (FILT_W < 1) begin : g_bad_filt
      $error("stt_in_cond: FILT_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
   end
   assign synced = sync_q[SYNC_STAGES-1];

   generate
      if (USE_FILTER) begin : g_filt
         logic [FILT_W-1:0] run_q;
         logic [FILT_W:0]   run_inc;
         assign run_inc = {1'b0, run_q} + {{FILT_W{1'b0}}, 1'b1};

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               clean_o <= 1'b0;
               run_q   <= '0;
            end else if (synced == clean_o) begin
               run_q   <= '0;
            end else if (run_inc >= {1'b0, flen_i}) begin
               clean_o <= synced;
               run_q   <= '0;
            end else begin
               run_q   <= run_inc[FILT_W-1:0];
            end
         end

         AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (synced == clean_o) |=> $stable(clean_o)); // R8
      end else begin : g_bypass
         logic unused_flen;
         assign unused_flen = ^flen_i;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) clean_o <= 1'b0;
            else        clean_o <= synced;
         end
      end
   endgenerate
endmodule

// File: rtl/stt_edge_sel.sv
`timescale 1ns/1ps
module stt_edge_sel
   import stt_pkg::*;
(
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] clean_i,
   input  logic [4:0]     src_i,
   input  logic [NCH-1:0] pol_p_i,
   input  logic [NCH-1:0] pol_np_i,
   output logic           edge_o,
   output logic           level_o
);
   logic [NCH-1:0] prev_q;
   logic [NCH-1:0] ch_edge;
   logic [NCH-1:0] ch_level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= clean_i;
   end

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic rise, fall;
      assign rise        = clean_i[i] & ~prev_q[i];
      assign fall        = ~clean_i[i] & prev_q[i];
      assign ch_edge[i]  = (pol_p_i[i] & pol_np_i[i]) ? (rise | fall) :
                           pol_p_i[i]                 ? fall : rise;
      assign ch_level[i] = clean_i[i] ^ pol_p_i[i];
   end

   always_comb begin
      edge_o  = 1'b0;
      level_o = 1'b0;
      case (src_i)
         SRC_CH1: begin edge_o = ch_edge[0]; level_o = ch_level[0]; end
         SRC_CH2: begin edge_o = ch_edge[1]; level_o = ch_level[1]; end
         default: ;
      endcase
   end

   AST_NO_SRC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (src_i != SRC_CH1 && src_i != SRC_CH2) |-> (!edge_o && !level_o)); // R5
endmodule

// File: rtl/stt_slave_ctl.sv
`timescale 1ns/1ps
module stt_slave_ctl
   import stt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] mode_i,
   input  logic       edge_i,
   input  logic       level_i,
   input  logic       clr_i,
   output logic       en_o,
   output logic       flag_o
);
   logic en_nxt;
   logic set_flag;

   always_comb begin
      case (mode_i)
         SM_TRIG:  en_nxt = en_o | edge_i;
         SM_GATED: en_nxt = level_i;
         default:  en_nxt = 1'b0;
      endcase
      set_flag = ((mode_i == SM_TRIG) && edge_i) ||
                 ((mode_i == SM_GATED) && (en_nxt != en_o));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o   <= 1'b0;
         flag_o <= 1'b0;
      end else begin
         en_o <= en_nxt;
         if (set_flag)   flag_o <= 1'b1;
         else if (clr_i) flag_o <= 1'b0;
      end
   end

   AST_TRIG_START: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == SM_TRIG && edge_i) |=> (en_o && flag_o)); // R2
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == SM_TRIG && en_o) |=> (en_o || mode_i != SM_TRIG)); // R3
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o); // R4
   AST_GATE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == SM_GATED && level_i != en_o) |=> flag_o); // R10
   AST_OFF_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i != SM_TRIG && mode_i != SM_GATED) |=> !en_o); // R12
endmodule

// File: rtl/stt_counter.sv
`timescale 1ns/1ps
module stt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic [CNT_W-1:0] count_o
);
   if (CNT_W < 2) begin : g_bad_w
      $error("stt_counter: CNT_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     count_o <= '0;
      else if (en_i) begin
         if (count_o == reload_i)     count_o <= '0;
         else                         count_o <= count_o + 1'b1;
      end
   end

   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && count_o == reload_i) |=> (count_o == '0)); // R11
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> $stable(count_o)); // R9
endmodule

// File: rtl/stt_timer.sv
`timescale 1ns/1ps
module stt_timer
   import stt_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int FILT_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit USE_FILTER  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCH-1:0]   ext_in,
   input  logic [2:0]       mode_sel,
   input  logic [4:0]       trig_src,
   input  logic [2*NCH-1:0] ch_route,
   input  logic [NCH-1:0]   pol_p,
   input  logic [NCH-1:0]   pol_np,
   input  logic [FILT_W-1:0] filt_len,
   input  logic [CNT_W-1:0] reload,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] count,
   output logic             cnt_en,
   output logic             trig_flag
);
   logic [NCH-1:0] routed;
   logic [NCH-1:0] clean;
   logic           sel_edge;
   logic           sel_level;

   for (genvar i = 0; i < NCH; i++) begin : g_chan
      logic [1:0] rt;
      assign rt = ch_route[2*i +: 2];
      assign routed[i] = (rt == RT_OWN)  ? ext_in[i] :
                         (rt == RT_SWAP) ? ext_in[NCH-1-i] : 1'b0;

      stt_in_cond #(
         .SYNC_STAGES (SYNC_STAGES),
         .FILT_W      (FILT_W),
         .USE_FILTER  (USE_FILTER)
      ) u_cond (
         .clk     (clk),
         .rst_n   (rst_n),
         .raw_i   (routed[i]),
         .flen_i  (filt_len),
         .clean_o (clean[i])
      );
   end

   stt_edge_sel u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .clean_i  (clean),
      .src_i    (trig_src),
      .pol_p_i  (pol_p),
      .pol_np_i (pol_np),
      .edge_o   (sel_edge),
      .level_o  (sel_level)
   );

   stt_slave_ctl u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode_i  (mode_sel),
      .edge_i  (sel_edge),
      .level_i (sel_level),
      .clr_i   (flag_clr),
      .en_o    (cnt_en),
      .flag_o  (trig_flag)
   );

   stt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (cnt_en),
      .reload_i (reload),
      .count_o  (count)
   );
endmodule

// File: tb/sim_stt_timer.sv
`timescale 1ns/1ps
module sim_stt_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  ext_in = '0;
   logic [2:0]  mode_sel = '0;
   logic [4:0]  trig_src = '0;
   logic [3:0]  ch_route = 4'b0101;
   logic [1:0]  pol_p = '0;
   logic [1:0]  pol_np = '0;
   logic [3:0]  filt_len = '0;
   logic [15:0] reload = 16'd1000;
   logic        flag_clr = 1'b0;
   logic [15:0] count;
   logic        cnt_en;
   logic        trig_flag;

   stt_timer u0 (
      .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .mode_sel(mode_sel),
      .trig_src(trig_src), .ch_route(ch_route), .pol_p(pol_p), .pol_np(pol_np),
      .filt_len(filt_len), .reload(reload), .flag_clr(flag_clr),
      .count(count), .cnt_en(cnt_en), .trig_flag(trig_flag)
   );

   always #5 clk = ~clk;

   typedef struct {
      string r;
      int    c;
      bit    e;
      bit    f;
   } exp_t;

   exp_t exp_q[$];
   int   n_run  = 0;
   int   n_fail = 0;
   int   edges  = 0;
   int   t_en   = 0;
   bit   done   = 1'b0;

   // monitor: pops one expectation per clock edge and compares
   always @(posedge clk) begin
      #2;
      edges++;
      if (exp_q.size() > 0) begin
         exp_t it;
         it = exp_q.pop_front();
         n_run++;
         if (int'(count) != it.c || cnt_en != it.e || trig_flag != it.f) begin
            n_fail++;
            $display("FAIL %s: actual count=%0d en=%0b flag=%0b expected count=%0d en=%0b flag=%0b",
                     it.r, count, cnt_en, trig_flag, it.c, it.e, it.f);
         end
      end
   end

   // driver helpers: expectation describes the state after the coming edge
   task automatic chk(input string r, input int c, input bit e, input bit f);
      exp_t it;
      it.r = r; it.c = c; it.e = e; it.f = f;
      exp_q.push_back(it);
      @(negedge clk);
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int run();
      return edges + 1 - t_en;
   endfunction

   task automatic do_reset(input logic [15:0] rl);
      @(negedge clk);
      rst_n = 1'b0; ext_in = '0; flag_clr = 1'b0; mode_sel = '0;
      trig_src = '0; ch_route = 4'b0101; pol_p = '0; pol_np = '0;
      filt_len = '0; reload = rl;
      tick(3);
      rst_n = 1'b1;
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog (all R) actual=timeout expected=finish");
         summary();
         $finish;
      end
   end

   initial begin
      int v;
      // R1 reset state
      do_reset(16'd1000);
      chk("R1", 0, 0, 0);

      // R2 trigger start and exact latency, R4 flag, R3 re-trigger
      mode_sel = 3'b110; trig_src = 5'b00110;
      tick(2);
      ext_in[1] = 1'b1;
      tick(2);
      chk("R2", 0, 0, 0);
      t_en = edges + 1;
      chk("R2", 0, 1, 1);
      chk("R2", 1, 1, 1);
      tick(4);
      chk("R4", run(), 1, 1);
      flag_clr = 1'b1;
      chk("R4", run(), 1, 0);
      flag_clr = 1'b0;
      ext_in[1] = 1'b0;
      tick(5);
      chk("R7", run(), 1, 0);
      ext_in[1] = 1'b1;
      tick(2);
      chk("R3", run(), 1, 0);
      chk("R3", run(), 1, 1);

      // R12 leaving the counting modes
      mode_sel = 3'b000;
      v = run();
      chk("R12", v, 0, 1);
      chk("R12", v, 0, 1);
      tick(3);
      chk("R12", v, 0, 1);

      // R6 routing held low, R5 invalid source, then crossed routing into channel 1
      do_reset(16'd1000);
      mode_sel = 3'b110; trig_src = 5'b00110; ch_route = 4'b0001;
      tick(2);
      ext_in[1] = 1'b1;
      tick(8);
      chk("R6", 0, 0, 0);
      ext_in[1] = 1'b0;
      tick(6);
      ch_route = 4'b0101; trig_src = 5'b00111;
      tick(2);
      ext_in[1] = 1'b1;
      tick(8);
      chk("R5", 0, 0, 0);
      ext_in[1] = 1'b0;
      tick(6);
      ch_route = 4'b0110; trig_src = 5'b00101;
      tick(2);
      ext_in[1] = 1'b1;
      tick(2);
      chk("R6", 0, 0, 0);
      chk("R5", 0, 1, 1);

      // R7 falling sense
      do_reset(16'd1000);
      mode_sel = 3'b110; trig_src = 5'b00110; pol_p = 2'b10;
      tick(2);
      ext_in[1] = 1'b1;
      tick(8);
      chk("R7", 0, 0, 0);
      ext_in[1] = 1'b0;
      tick(2);
      chk("R7", 0, 0, 0);
      chk("R7", 0, 1, 1);

      // R7 both edges
      do_reset(16'd1000);
      mode_sel = 3'b110; trig_src = 5'b00110; pol_p = 2'b10; pol_np = 2'b10;
      tick(2);
      ext_in[1] = 1'b1;
      tick(2);
      chk("R7", 0, 0, 0);
      t_en = edges + 1;
      chk("R7", 0, 1, 1);
      flag_clr = 1'b1;
      chk("R4", run(), 1, 0);
      flag_clr = 1'b0;
      ext_in[1] = 1'b0;
      tick(2);
      chk("R7", run(), 1, 0);
      chk("R7", run(), 1, 1);

      // R8 filter of three samples
      do_reset(16'd1000);
      filt_len = 4'd3; mode_sel = 3'b110; trig_src = 5'b00110;
      tick(2);
      ext_in[1] = 1'b1;
      tick(2);
      ext_in[1] = 1'b0;
      tick(8);
      chk("R8", 0, 0, 0);
      ext_in[1] = 1'b1;
      tick(4);
      chk("R8", 0, 0, 0);
      t_en = edges + 1;
      chk("R8", 0, 1, 1);
      chk("R8", 1, 1, 1);

      // R9 / R10 gated, active low, both-edges bit ignored
      do_reset(16'd1000);
      mode_sel = 3'b101; trig_src = 5'b00110; pol_p = 2'b10; pol_np = 2'b10;
      t_en = edges + 1;
      chk("R9", 0, 1, 1);
      chk("R9", 1, 1, 1);
      flag_clr = 1'b1;
      chk("R10", run(), 1, 0);
      flag_clr = 1'b0;
      ext_in[1] = 1'b1;
      tick(2);
      chk("R9", run(), 1, 0);
      v = run();
      chk("R10", v, 0, 1);
      chk("R9", v, 0, 1);
      tick(4);
      chk("R9", v, 0, 1);
      flag_clr = 1'b1;
      chk("R10", v, 0, 0);
      flag_clr = 1'b0;
      ext_in[1] = 1'b0;
      tick(2);
      chk("R9", v, 0, 0);
      chk("R10", v, 1, 1);
      chk("R9", v + 1, 1, 1);

      // R11 wrap at reload
      do_reset(16'd3);
      mode_sel = 3'b110; trig_src = 5'b00110;
      tick(2);
      ext_in[1] = 1'b1;
      tick(3);
      chk("R11", 0, 1, 1);
      chk("R11", 1, 1, 1);
      chk("R11", 2, 1, 1);
      chk("R11", 3, 1, 1);
      chk("R11", 0, 1, 1);
      chk("R11", 1, 1, 1);

      tick(3);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule